// File: doc/BRIEF.md
# DDR SDRAM Power-Up and Refresh Sequencer

This controller-side block owns the command pins of a DDR SDRAM from reset until the memory is usable. It then keeps the memory refreshed. After reset it holds the clock-enable low for a settling period. It then raises clock-enable and steps through a fixed bring-up order:

1. An extended mode write that turns the DLL on.
2. A mode write that resets the DLL.
3. A precharge of every bank.
4. A programmable number of auto-refreshes.
5. A final mode write carrying the operating settings.

Every gap between these steps is a parameter counted in clock cycles. The ready flag rises only when the final mode write has settled and the DLL lock window, measured from the DLL reset, has run out.

Once the memory is ready, an interval counter marks each refresh as due and keeps a saturating tally of refreshes that are owed. A request output tells an outside arbiter that refreshes are pending. A refresh is placed on the bus only in a cycle where the arbiter's grant is sampled high. The busy output then covers the refresh recovery time. Every cycle that carries no command shows a NOP.

Top module: `dram_bringup_seq`

## Requirements
- R1: After reset, `cke` is low and the pins carry NOP (csN=0, rasN=1, casN=1, weN=1). `cke` rises exactly STABLE_CYC clock edges after reset release and stays high.
- R2: The first command is an extended mode write (csN,rasN,casN,weN = 0000, bankSel = 01). Its address is `extModeWord` with bit 0 forced to 0. It appears MRD_CYC edges after `cke` rises.
- R3: MRD_CYC edges after the extended write comes a DLL-reset mode write (0000, bankSel = 00). Its address is `modeWord` with bit 8 forced to 1.
- R4: MRD_CYC edges later comes precharge-all (0010), with only address bit 10 set and bankSel = 00.
- R5: INIT_REFS auto-refreshes (0001, address 0) follow. The first comes RP_CYC edges after the precharge, and the later ones come RFC_CYC edges apart.
- R6: RFC_CYC edges after the last start-up refresh comes the final mode write (0000, bankSel = 00). Its address is `modeWord` with bit 8 forced to 0.
- R7: `initDone` rises at the later of two edges: the final mode write plus MRD_CYC, or the DLL-reset write plus DLL_CYC. Once high, it stays high.
- R8: Every cycle that is not one of the listed commands carries NOP. `refGrant` has no effect before `initDone`.
- R9: `refReq` rises REFI_CYC edges after `initDone`, and one more refresh becomes owed every REFI_CYC edges after that. `refReq` is high whenever at least one refresh is owed.
- R10: When `refGrant` is high and a refresh is owed, the refresh command appears on the next edge and the owed tally drops by one.
- R11: The owed tally saturates at MAX_OWED. After a long wait without grant, exactly MAX_OWED refreshes are issued before `refReq` falls.
- R12: `refBusy` is high for exactly RFC_CYC cycles, starting with the refresh command cycle. Grant is ignored while it is high, so back-to-back refreshes are RFC_CYC+1 edges apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| extModeWord | input | ADDR_W | Address value for the extended mode write (bit 0 overridden) |
| modeWord | input | ADDR_W | Operating mode value (bit 8 overridden per step) |
| refGrant | input | 1 | Arbiter permission to issue a pending refresh |
| cke | output | 1 | Clock enable to the memory |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| bankSel | output | 2 | Bank select |
| addr | output | ADDR_W | Address bus |
| initDone | output | 1 | Bring-up complete |
| refReq | output | 1 | At least one refresh is owed |
| refBusy | output | 1 | Refresh recovery in progress |

## Verification
All command pins are registered. A command decided in one cycle therefore shows on the pins after the next rising edge. Every gap in the requirements is measured edge to edge between commands on the pins. The bench counts rising edges since reset release and pushes each expected command with its exact edge number, its pins, its bank and its address into a queue. A monitor samples on the falling edge, pops the queue on every non-NOP cycle and compares all four fields. Any command that is not in the queue fails as a stray. Level checks on `cke`, `initDone`, `refReq` and `refBusy` are taken on the falling edge just before and just after the edge on which each is due to change.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_EMRS,
    CMD_MRS_DLL,
    CMD_MRS_OP,
    CMD_PREA,
    CMD_REF
  } cmdKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     fire;
    cmdKind_e kind;
    logic     ckeOn;
    logic     dllStart;
    logic     doneSet;
    logic     refTake;
  } strobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bringup_ctrl.sv
module bringup_ctrl
  import bringup_pkg::*;
#(
  parameter int INIT_REFS = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    waitZero,
  input  logic    dllZero,
  input  logic    owedAny,
  input  logic    refGrant,
  output strobe_t stb,
  output logic    refBusy
);

  localparam int IDX_W = $clog2(INIT_REFS + 1);

  typedef enum logic [3:0] {
    ST_STABLE,
    ST_EMRS,
    ST_MRSDLL,
    ST_PREA,
    ST_INITREF,
    ST_MRSOP,
    ST_LOCK,
    ST_READY,
    ST_RBUSY
  } state_e;

  state_e             state, stateNext;
  logic [IDX_W-1:0]   refIdx;

  always_comb begin
    stb       = '0;
    stateNext = state;
    case (state)
      ST_STABLE: if (waitZero) begin
        stb.ckeOn = 1'b1;
        stateNext = ST_EMRS;
      end
      ST_EMRS: if (waitZero) begin
        stb.fire  = 1'b1;
        stb.kind  = CMD_EMRS;
        stateNext = ST_MRSDLL;
      end
      ST_MRSDLL: if (waitZero) begin
        stb.fire     = 1'b1;
        stb.kind     = CMD_MRS_DLL;
        stb.dllStart = 1'b1;
        stateNext    = ST_PREA;
      end
      ST_PREA: if (waitZero) begin
        stb.fire  = 1'b1;
        stb.kind  = CMD_PREA;
        stateNext = ST_INITREF;
      end
      ST_INITREF: if (waitZero) begin
        stb.fire = 1'b1;
        stb.kind = CMD_REF;
        if (refIdx == IDX_W'(INIT_REFS - 1)) stateNext = ST_MRSOP;
      end
      ST_MRSOP: if (waitZero) begin
        stb.fire  = 1'b1;
        stb.kind  = CMD_MRS_OP;
        stateNext = ST_LOCK;
      end
      ST_LOCK: if (waitZero && dllZero) begin
        stb.doneSet = 1'b1;
        stateNext   = ST_READY;
      end
      ST_READY: if (owedAny && refGrant) begin
        stb.fire    = 1'b1;
        stb.kind    = CMD_REF;
        stb.refTake = 1'b1;
        stateNext   = ST_RBUSY;
      end
      ST_RBUSY: if (waitZero) stateNext = ST_READY;
      default: stateNext = ST_STABLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state  <= ST_STABLE;
      refIdx <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_INITREF && waitZero) refIdx <= refIdx + 1'b1;
    end
  end

  assign refBusy = (state == ST_RBUSY);

endmodule

// File: rtl/bringup_dp.sv
module bringup_dp
  import bringup_pkg::*;
#(
  parameter int STABLE_CYC = 20000,
  parameter int MRD_CYC    = 2,
  parameter int RP_CYC     = 3,
  parameter int RFC_CYC    = 8,
  parameter int DLL_CYC    = 200,
  parameter int REFI_CYC   = 780,
  parameter int MAX_OWED   = 8,
  parameter int ADDR_W     = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] extModeWord,
  input  logic [ADDR_W-1:0] modeWord,
  output logic              waitZero,
  output logic              dllZero,
  output logic              owedAny,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [1:0]        bankSel,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone
);

  localparam int WAIT_MAX = maxOf(maxOf(STABLE_CYC, MRD_CYC), maxOf(RP_CYC, RFC_CYC));
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int DLL_W    = $clog2(DLL_CYC + 1);
  localparam int REFI_W   = $clog2(REFI_CYC + 1);
  localparam int OWED_W   = $clog2(MAX_OWED + 1);
  localparam int DLL_BIT  = 8;
  localparam int AP_BIT   = 10;

  logic [WAIT_W-1:0] waitCnt, gapLoad;
  logic [DLL_W-1:0]  dllCnt;
  logic [REFI_W-1:0] refiCnt;
  logic [OWED_W-1:0] owed;
  logic              refiTick, owedInc;
  logic [3:0]        pinsNext;
  logic [1:0]        bankNext;
  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    case (stb.kind)
      CMD_PREA: gapLoad = WAIT_W'(RP_CYC - 1);
      CMD_REF:  gapLoad = WAIT_W'(RFC_CYC - 1);
      default:  gapLoad = WAIT_W'(MRD_CYC - 1);
    endcase
  end

  always_comb begin
    pinsNext = 4'b0111;
    bankNext = 2'b00;
    addrNext = '0;
    if (stb.fire) begin
      case (stb.kind)
        CMD_EMRS: begin
          pinsNext = 4'b0000;
          bankNext = 2'b01;
          addrNext = extModeWord & ~(ADDR_W'(1));
        end
        CMD_MRS_DLL: begin
          pinsNext = 4'b0000;
          addrNext = modeWord | (ADDR_W'(1) << DLL_BIT);
        end
        CMD_MRS_OP: begin
          pinsNext = 4'b0000;
          addrNext = modeWord & ~(ADDR_W'(1) << DLL_BIT);
        end
        CMD_PREA: begin
          pinsNext = 4'b0010;
          addrNext = ADDR_W'(1) << AP_BIT;
        end
        CMD_REF: pinsNext = 4'b0001;
        default: pinsNext = 4'b0111;
      endcase
    end
  end

  assign refiTick = initDone && (refiCnt == '0);
  assign owedInc  = refiTick && ((owed != OWED_W'(MAX_OWED)) || stb.refTake);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      waitCnt  <= WAIT_W'(STABLE_CYC - 1);
      dllCnt   <= '0;
      refiCnt  <= '0;
      owed     <= '0;
      initDone <= 1'b0;
      cke      <= 1'b0;
      {csN, rasN, casN, weN} <= 4'b0111;
      bankSel  <= 2'b00;
      addr     <= '0;
    end else begin
      if (stb.ckeOn)          waitCnt <= WAIT_W'(MRD_CYC - 1);
      else if (stb.fire)      waitCnt <= gapLoad;
      else if (waitCnt != '0) waitCnt <= waitCnt - 1'b1;

      if (stb.dllStart)      dllCnt <= DLL_W'(DLL_CYC - 1);
      else if (dllCnt != '0) dllCnt <= dllCnt - 1'b1;

      if (!initDone || refiTick) refiCnt <= REFI_W'(REFI_CYC - 1);
      else                       refiCnt <= refiCnt - 1'b1;

      case ({owedInc, stb.refTake})
        2'b10:   owed <= owed + 1'b1;
        2'b01:   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase

      if (stb.doneSet) initDone <= 1'b1;
      if (stb.ckeOn)   cke      <= 1'b1;
      {csN, rasN, casN, weN} <= pinsNext;
      bankSel <= bankNext;
      addr    <= addrNext;
    end
  end

  assign waitZero = (waitCnt == '0);
  assign dllZero  = (dllCnt == '0);
  assign owedAny  = (owed != '0);

endmodule

// File: rtl/dram_bringup_seq.sv
module dram_bringup_seq
  import bringup_pkg::*;
#(
  parameter int STABLE_CYC = 20000,
  parameter int MRD_CYC    = 2,
  parameter int RP_CYC     = 3,
  parameter int RFC_CYC    = 8,
  parameter int DLL_CYC    = 200,
  parameter int REFI_CYC   = 780,
  parameter int INIT_REFS  = 2,
  parameter int MAX_OWED   = 8,
  parameter int ADDR_W     = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] extModeWord,
  input  logic [ADDR_W-1:0] modeWord,
  input  logic              refGrant,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [1:0]        bankSel,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone,
  output logic              refReq,
  output logic              refBusy
);

  strobe_t stb;
  logic    waitZero, dllZero, owedAny;

  bringup_ctrl #(.INIT_REFS(INIT_REFS)) u_ctrl (
    .clk(clk), .rst(rst), .waitZero(waitZero), .dllZero(dllZero),
    .owedAny(owedAny), .refGrant(refGrant), .stb(stb), .refBusy(refBusy)
  );

  bringup_dp #(
    .STABLE_CYC(STABLE_CYC), .MRD_CYC(MRD_CYC), .RP_CYC(RP_CYC),
    .RFC_CYC(RFC_CYC), .DLL_CYC(DLL_CYC), .REFI_CYC(REFI_CYC),
    .MAX_OWED(MAX_OWED), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .extModeWord(extModeWord),
    .modeWord(modeWord), .waitZero(waitZero), .dllZero(dllZero),
    .owedAny(owedAny), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankSel(bankSel), .addr(addr), .initDone(initDone)
  );

  assign refReq = owedAny;

endmodule

// File: rtl/dram_bringup_seq_chk.sv
module dram_bringup_seq_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              refGrant,
  input logic              cke,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [1:0]        bankSel,
  input logic [ADDR_W-1:0] addr,
  input logic              initDone,
  input logic              refReq,
  input logic              refBusy
);

  logic isNop, isRef;
  assign isNop = ({csN, rasN, casN, weN} == 4'b0111);
  assign isRef = ({csN, rasN, casN, weN} == 4'b0001);

  assert_cke_stays_R1: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  assert_cmd_needs_cke_R1: assert property (@(posedge clk) disable iff (rst)
    !isNop |-> cke);

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    initDone |=> initDone);

  assert_req_after_init_R9: assert property (@(posedge clk) disable iff (rst)
    refReq |-> initDone);

  assert_ref_granted_R10: assert property (@(posedge clk) disable iff (rst)
    (isRef && $past(initDone)) |-> ($past(refGrant) && $past(refReq)));

  assert_busy_starts_ref_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(refBusy) |-> isRef);

  assert_quiet_when_busy_R12: assert property (@(posedge clk) disable iff (rst)
    (refBusy && $past(refBusy)) |-> isNop);

endmodule

bind dram_bringup_seq dram_bringup_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .refGrant(refGrant), .cke(cke), .csN(csN),
  .rasN(rasN), .casN(casN), .weN(weN), .bankSel(bankSel), .addr(addr),
  .initDone(initDone), .refReq(refReq), .refBusy(refBusy)
);

// File: tb/dram_bringup_seq_tb.sv
module dram_bringup_seq_tb;

  localparam int STABLE = 20;
  localparam int MRD    = 2;
  localparam int RP     = 3;
  localparam int RFC    = 8;
  localparam int DLL    = 200;
  localparam int REFI   = 100;
  localparam int NREF   = 2;
  localparam int OWEMAX = 8;
  localparam int AW     = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] extModeWord = 13'h0003;
  logic [AW-1:0] modeWord    = 13'h0122;
  logic          refGrant    = 1'b1;
  logic          cke, csN, rasN, casN, weN, initDone, refReq, refBusy;
  logic [1:0]    bankSel;
  logic [AW-1:0] addr;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  typedef struct {
    int          edgeNo;
    logic [3:0]  pins;
    logic [1:0]  bank;
    logic [AW-1:0] adr;
    string       req;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t curItem;

  dram_bringup_seq #(
    .STABLE_CYC(STABLE), .MRD_CYC(MRD), .RP_CYC(RP), .RFC_CYC(RFC),
    .DLL_CYC(DLL), .REFI_CYC(REFI), .INIT_REFS(NREF), .MAX_OWED(OWEMAX),
    .ADDR_W(AW)
  ) u_dut (
    .clk(clk), .rst(rst), .extModeWord(extModeWord), .modeWord(modeWord),
    .refGrant(refGrant), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankSel(bankSel), .addr(addr), .initDone(initDone),
    .refReq(refReq), .refBusy(refBusy)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic pushExp(input int e, input logic [3:0] p, input logic [1:0] b,
                         input logic [AW-1:0] a, input string r);
    expItem_t it;
    it.edgeNo = e; it.pins = p; it.bank = b; it.adr = a; it.req = r;
    expQ.push_back(it);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitEdge(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: every non-NOP cycle must match the head of the queue (R8)
  always @(negedge clk) begin
    if (!rst && ({csN, rasN, casN, weN} != 4'b0111)) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R8 stray command at edge %0d actual=%b expected=0111",
                 cyc, {csN, rasN, casN, weN});
      end else begin
        curItem = expQ.pop_front();
        if (cyc != curItem.edgeNo || {csN, rasN, casN, weN} != curItem.pins ||
            bankSel != curItem.bank || addr != curItem.adr) begin
          errors++;
          $display("FAIL %s actual edge=%0d pins=%b bank=%0d addr=%h expected edge=%0d pins=%b bank=%0d addr=%h",
                   curItem.req, cyc, {csN, rasN, casN, weN}, bankSel, addr,
                   curItem.edgeNo, curItem.pins, curItem.bank, curItem.adr);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int tEmrs, tDll, tPrea, tRef0, tOp, tDone, tSat, tNext;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cke == 1'b0, "R1", "cke in reset", cke, 0);
    check({csN, rasN, casN, weN} == 4'b0111, "R1", "pins in reset",
          {csN, rasN, casN, weN}, 7);
    check(!initDone && !refReq && !refBusy, "R7", "flags in reset",
          {initDone, refReq, refBusy}, 0);
    rst = 1'b0;

    tEmrs = STABLE + MRD;
    tDll  = tEmrs + MRD;
    tPrea = tDll + MRD;
    tRef0 = tPrea + RP;
    tOp   = tRef0 + (NREF - 1) * RFC + RFC;
    tDone = (tOp + MRD > tDll + DLL) ? tOp + MRD : tDll + DLL;
    pushExp(tEmrs, 4'b0000, 2'b01, 13'h0002, "R2");
    pushExp(tDll,  4'b0000, 2'b00, 13'h0122, "R3");
    pushExp(tPrea, 4'b0010, 2'b00, 13'h0400, "R4");
    for (int k = 0; k < NREF; k++) pushExp(tRef0 + k * RFC, 4'b0001, 2'b00, '0, "R5");
    pushExp(tOp,   4'b0000, 2'b00, 13'h0022, "R6");

    waitEdge(STABLE - 1);
    check(cke == 1'b0, "R1", "cke before settle", cke, 0);
    waitEdge(STABLE);
    check(cke == 1'b1, "R1", "cke after settle", cke, 1);
    waitEdge(tDone - 1);
    check(initDone == 1'b0, "R7", "initDone early", initDone, 0);
    waitEdge(tDone);
    check(initDone == 1'b1, "R7", "initDone on time", initDone, 1);
    refGrant = 1'b0;   // grant was high during bring-up: R8

    waitEdge(tDone + REFI - 1);
    check(refReq == 1'b0, "R9", "refReq early", refReq, 0);
    waitEdge(tDone + REFI);
    check(refReq == 1'b1, "R9", "refReq on time", refReq, 1);

    tSat = tDone + 10 * REFI;
    waitEdge(tSat + 1);
    check(refReq == 1'b1 && initDone, "R11", "refReq while owed", refReq, 1);
    for (int k = 0; k < OWEMAX; k++)
      pushExp(tSat + 2 + k * (RFC + 1), 4'b0001, 2'b00, '0, (k == 0) ? "R10" : "R11");
    refGrant = 1'b1;
    waitEdge(tSat + 2);
    check(refBusy == 1'b1, "R12", "busy at refresh", refBusy, 1);
    waitEdge(tSat + 2 + RFC - 1);
    check(refBusy == 1'b1, "R12", "busy last cycle", refBusy, 1);
    waitEdge(tSat + 2 + RFC);
    check(refBusy == 1'b0, "R12", "busy cleared", refBusy, 0);
    waitEdge(tSat + 2 + (OWEMAX - 1) * (RFC + 1));
    check(refReq == 1'b0, "R11", "tally drained", refReq, 0);

    tNext = tDone + 11 * REFI;
    pushExp(tNext + 1, 4'b0001, 2'b00, '0, "R10");
    waitEdge(tNext - 1);
    check(refReq == 1'b0, "R9", "no owe before interval", refReq, 0);
    waitEdge(tNext);
    check(refReq == 1'b1, "R9", "owe at interval", refReq, 1);
    waitEdge(tNext + 1);
    check(refReq == 1'b0 && refBusy == 1'b1, "R10", "granted at once",
          {refReq, refBusy}, 1);
    waitEdge(tNext + 1 + RFC);
    check(refBusy == 1'b0, "R12", "busy length", refBusy, 0);
    waitEdge(tNext + 60);
    check(expQ.size() == 0, "R8", "expected commands left", expQ.size(), 0);
    check(initDone == 1'b1 && cke == 1'b1, "R7", "levels held",
          {initDone, cke}, 3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule